// File: doc/BRIEF.md
# Signed Fixed-Point Multiplier, Same-Format Output

This block multiplies two signed two's-complement fixed-point operands that share one Q format: INT_BITS integer bits (the sign included) and FRAC_BITS fraction bits, in a word of W = INT_BITS + FRAC_BITS bits. A bit vector x stands for x·2^-FRAC_BITS. The result comes back in that same format, so it can go straight into further arithmetic of the same width.

The block is purely combinational. It forms the exact double-width signed product and picks out the W bits that line up with the operands' binary point. A per-operation enable rounds to nearest, with halves going up, by adding the first discarded fraction bit. A flag marks results that the format cannot hold. Even then the output keeps the wrapped bit pattern and is not clamped, so the caller decides how to handle the overflow.

Top module: `qfix_mul`

## Requirements
- R1: With rnd_en_i = 0, result_o equals floor(A·B / 2^FRAC_BITS) taken modulo 2^W, where A and B are the operands read as signed W-bit integers. This truncates toward negative infinity.
- R2: With rnd_en_i = 1, result_o equals floor((A·B + 2^(FRAC_BITS-1)) / 2^FRAC_BITS) modulo 2^W. Equivalently, one is added to the truncated field when product bit FRAC_BITS-1 is set.
- R3: overflow_o is 1 whenever the truncated value floor(A·B / 2^FRAC_BITS) lies outside [-2^(W-1), 2^(W-1)-1]. Otherwise, with rnd_en_i = 0, it is 0.
- R4: With rnd_en_i = 1, overflow_o is also 1 when the rounding increment carries the largest positive value over to the most negative one. An example is 1.5 × 5.3125 in the default format: result 0x80, overflow 1.
- R5: On overflow no saturation is applied: result_o still carries the low W bits of the selected value. For example, -8.0 × -8.0 in the default format gives 0x00 with overflow 1.
- R6: With rnd_en_i = 0 the discarded fraction bits have no effect on result_o or overflow_o.
- R7: The outputs depend only on the present inputs. There is no clock, no reset and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | Multiplicand, signed, FRAC_BITS fraction bits |
| b_i | input | W | Multiplier, signed, FRAC_BITS fraction bits |
| rnd_en_i | input | 1 | 1: round to nearest (half up); 0: truncate |
| result_o | output | W | Product in the same Q format, wrapped on overflow |
| overflow_o | output | 1 | Product not representable in the format |

## Verification
The bench builds the block with its defaults: 4 integer bits and 4 fraction bits, an 8-bit word. That width makes every operand pair in both rounding modes reachable, so all 131072 combinations are compared against wide-integer arithmetic. The sweep therefore covers the most negative value times itself, the extreme mixed-sign products, -1 × -1, zero operands, and every case where rounding carries into the sign bit. Directed vectors with hand-computed results come before the sweep.

// File: rtl/qfix_pkg.sv
package qfix_pkg;
  // true when every bit of v is equal (pure sign extension)
  function automatic logic all_same(input logic [63:0] v, input int unsigned n);
    logic ref_b;
    logic same;
    ref_b = v[0];
    same = 1'b1;
    for (int unsigned i = 1; i < 64; i++) begin
      if (i < n && v[i] != ref_b) same = 1'b0;
    end
    return same;
  endfunction
endpackage

// File: rtl/qfix_mul_core.sv
module qfix_mul_core #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);
  logic signed [2*W-1:0] a_ext, b_ext;
  assign a_ext = {{W{a_i[W-1]}}, a_i};
  assign b_ext = {{W{b_i[W-1]}}, b_i};
  assign prod_o = a_ext * b_ext;
endmodule

// File: rtl/qfix_mul_align.sv
module qfix_mul_align #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 4,
  localparam int unsigned HI_W = W - N + 1
) (
  input  logic [2*W-1:0]  prod_i,
  output logic [W-1:0]    kept_o,
  output logic            guard_o,
  output logic [HI_W-1:0] hi_o
);
  assign kept_o = prod_i[W+N-1:N];
  assign hi_o   = prod_i[2*W-1:W+N-1];

  generate
    if (N > 0) begin : g_guard
      assign guard_o = prod_i[N-1];
    end else begin : g_noguard
      assign guard_o = 1'b0;
    end
    if (N > 1) begin : g_low
      logic unused_low_bits;
      assign unused_low_bits = ^prod_i[N-2:0];
    end
  endgenerate
endmodule

// File: rtl/qfix_mul_round.sv
module qfix_mul_round #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] kept_i,
  input  logic         inc_i,
  output logic [W-1:0] sum_o,
  output logic         wrap_o
);
  assign sum_o  = kept_i + W'(inc_i);
  // carry into the sign: positive max stepped to negative min
  assign wrap_o = inc_i & ~kept_i[W-1] & sum_o[W-1];
endmodule

// File: rtl/qfix_mul_range.sv
module qfix_mul_range #(
  parameter int unsigned HI_W = 5
) (
  input  logic [HI_W-1:0] hi_i,
  output logic            out_of_range_o
);
  import qfix_pkg::*;
  assign out_of_range_o = ~all_same(64'(hi_i), HI_W);
endmodule

// File: rtl/qfix_mul.sv
module qfix_mul #(
  parameter int unsigned INT_BITS  = 4,
  parameter int unsigned FRAC_BITS = 4,
  localparam int unsigned W    = INT_BITS + FRAC_BITS,
  localparam int unsigned HI_W = INT_BITS + 1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         rnd_en_i,
  output logic [W-1:0] result_o,
  output logic         overflow_o
);
  logic [2*W-1:0]  prod;
  logic [W-1:0]    kept;
  logic            guard;
  logic [HI_W-1:0] hi;
  logic            range_ovf;
  logic            wrap;

  qfix_mul_core #(.W(W)) u_core (
    .a_i   (a_i),
    .b_i   (b_i),
    .prod_o(prod)
  );

  qfix_mul_align #(.W(W), .N(FRAC_BITS)) u_align (
    .prod_i (prod),
    .kept_o (kept),
    .guard_o(guard),
    .hi_o   (hi)
  );

  qfix_mul_range #(.HI_W(HI_W)) u_range (
    .hi_i          (hi),
    .out_of_range_o(range_ovf)
  );

  qfix_mul_round #(.W(W)) u_round (
    .kept_i(kept),
    .inc_i (rnd_en_i & guard),
    .sum_o (result_o),
    .wrap_o(wrap)
  );

  assign overflow_o = range_ovf | wrap;
endmodule

// File: rtl/qfix_mul_chk.sv
module qfix_mul_chk #(
  parameter int unsigned INT_BITS  = 4,
  parameter int unsigned FRAC_BITS = 4,
  localparam int unsigned W = INT_BITS + FRAC_BITS
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         rnd_en_i,
  input logic [W-1:0] result_o,
  input logic         overflow_o
);
  localparam logic [W-1:0] ONE     = W'(1) << FRAC_BITS;
  localparam logic [W-1:0] NEG_ONE = ~ONE + W'(1);
  localparam logic [W-1:0] MIN_V   = W'(1) << (W - 1);

  always_comb begin
    if (a_i == '0 || b_i == '0)
      assert_zero_operand_R1: assert (result_o == '0 && !overflow_o);
    if (a_i == ONE)
      assert_unit_operand_R2: assert (result_o == b_i && !overflow_o);
    if (a_i == NEG_ONE && b_i == MIN_V)
      assert_wrap_no_sat_R5: assert (result_o == MIN_V && overflow_o);
    if (!rnd_en_i && !overflow_o && !a_i[W-1] && !b_i[W-1])
      assert_nonneg_sign_R3: assert (!result_o[W-1]);
    if (rnd_en_i && !overflow_o && !a_i[W-1] && !b_i[W-1])
      assert_round_sign_R4: assert (!result_o[W-1]);
  end
endmodule

bind qfix_mul qfix_mul_chk #(.INT_BITS(INT_BITS), .FRAC_BITS(FRAC_BITS)) u_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .rnd_en_i  (rnd_en_i),
  .result_o  (result_o),
  .overflow_o(overflow_o)
);

// File: tb/qfix_mul_test.sv
`timescale 1ns/1ps
module qfix_mul_test;
  localparam int M = 4;
  localparam int N = 4;
  localparam int W = M + N;
  localparam longint MAXV = (64'sd1 <<< (W - 1)) - 1;
  localparam longint MINV = -(64'sd1 <<< (W - 1));

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] a, b, res;
  logic rnd, ovf;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  qfix_mul #(.INT_BITS(M), .FRAC_BITS(N)) uut (
    .a_i(a), .b_i(b), .rnd_en_i(rnd), .result_o(res), .overflow_o(ovf)
  );

  function automatic longint sx(input logic [W-1:0] v);
    return v[W-1] ? longint'(v) - (64'sd1 <<< W) : longint'(v);
  endfunction

  task automatic model(input logic [W-1:0] x, input logic [W-1:0] y, input logic r,
                       output logic [W-1:0] er, output logic eo);
    longint p, t, v;
    p = sx(x) * sx(y);
    t = p >>> N;
    v = r ? ((p + (64'sd1 <<< N) / 2) >>> N) : t;
    er = v[W-1:0];
    eo = (t > MAXV) || (t < MINV) || (v > MAXV) || (v < MINV);
  endtask

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h rnd=%b actual=%h expected=%h", tag, a, b, rnd, got, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic r);
    @(posedge clk);
    a = x; b = y; rnd = r;
    @(negedge clk);
  endtask

  task automatic directed(input string tr, input string to, input logic [W-1:0] x,
                          input logic [W-1:0] y, input logic r,
                          input logic [W-1:0] er, input logic eo);
    apply(x, y, r);
    chk(tr, res, er);
    chk(to, W'(ovf), W'(eo));
  endtask

  initial begin
    a = '0; b = '0; rnd = 1'b0;
    #1;
    chk("R7 idle zero result", res, '0);
    chk("R7 idle zero overflow", W'(ovf), '0);
    // 1.0625 x 1.5 = 1.59375: guard set
    directed("R6 trunc ignores guard", "R6 trunc ovf", 8'h11, 8'h18, 1'b0, 8'h19, 1'b0);
    directed("R2 round up", "R2 round ovf", 8'h11, 8'h18, 1'b1, 8'h1A, 1'b0);
    // 1.5 x 5.3125 = 7.96875: rounding carries into sign
    directed("R1 trunc max", "R3 no ovf", 8'h18, 8'h55, 1'b0, 8'h7F, 1'b0);
    directed("R4 round wrap result", "R4 round wrap ovf", 8'h18, 8'h55, 1'b1, 8'h80, 1'b1);
    directed("R5 min x min result", "R3 min x min ovf", 8'h80, 8'h80, 1'b0, 8'h00, 1'b1);
    directed("R5 min x max result", "R3 min x max ovf", 8'h80, 8'h7F, 1'b0, 8'h08, 1'b1);
    directed("R1 neg one squared", "R3 neg one ovf", 8'hF0, 8'hF0, 1'b0, 8'h10, 1'b0);
    directed("R1 zero operand", "R3 zero ovf", 8'h00, 8'h80, 1'b1, 8'h00, 1'b0);
    // -0.0625 x 0.5 = -0.03125: floor to -0.0625, round half up to 0
    directed("R1 neg trunc floor", "R3 neg trunc ovf", 8'hFF, 8'h08, 1'b0, 8'hFF, 1'b0);
    directed("R2 neg round half up", "R4 neg round ovf", 8'hFF, 8'h08, 1'b1, 8'h00, 1'b0);

    for (int r = 0; r < 2; r++) begin
      for (int x = 0; x < (1 << W); x++) begin
        for (int y = 0; y < (1 << W); y++) begin
          logic [W-1:0] er;
          logic eo;
          model(W'(x), W'(y), r[0], er, eo);
          apply(W'(x), W'(y), r[0]);
          if (r == 0) begin
            chk("R1 sweep result", res, er);
            chk("R3 sweep overflow", W'(ovf), W'(eo));
          end else begin
            chk("R2 sweep result", res, er);
            chk("R4 sweep overflow", W'(ovf), W'(eo));
          end
        end
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule